// File: doc/BRIEF.md
# PRBS7 Payload Self-Test Checker

This block sits on the receive side of a deserialized link and accepts one 24-bit payload per clock. While the self-test enable input is high, it checks the incoming payloads against a locally generated seven-stage pseudo-random pattern. Each payload that disagrees with the expected word in at least one bit counts as a single error event. Such an event pulses the `pass_o` output low for the low phase of the following clock and advances a saturating error counter. When the enable drops, checking stops. `pass_o` then holds the verdict of the run: high for a clean run, low if any error was seen. The verdict stays until the next run starts or reset is applied. The length of a run is set only by how long the enable stays high.

The checker needs no agreed seed. It loads its pattern state from the first valid payload of a run and compares from the next valid payload onward. Outside a test, payloads and their control bits pass through to a valid/ready output stream. During a test that stream is silenced: the output valid and data are held at zero and the input is always ready, so the link is never back-pressured while it is being measured. Outside a test, `in_ready_o` follows `out_ready_i` and a beat moves only when valid and ready are both high.

Top module: `prbs_payload_bist`

## Requirements
- R1: Synchronous active-high reset sets `pass_o` high, clears `err_count_o` and the held verdict, and makes `bist_active_o` low. This holds even in the middle of a run.
- R2: While `bist_active_o` is low, `out_valid_o`, `out_data_o` and `out_ctrl_o` follow `in_valid_i`, `in_data_i` and `in_ctrl_i`, and `in_ready_o` equals `out_ready_i`.
- R3: `bist_active_o` rises on the clock edge that samples `bist_en_i` high in idle. While `bist_active_o` is high, `out_valid_o`, `out_data_o` and `out_ctrl_o` are all zeros and `in_ready_o` is high.
- R4: The expected pattern obeys b[k] = b[k-6] XOR b[k-7] (polynomial x^7 + x^6 + 1). A payload carries 24 consecutive bits, with `in_data_i[23]` the oldest and `in_data_i[0]` the newest. The first valid payload of a run only seeds the state from `in_data_i[6:0]`. Every later valid payload is compared with the next 24 pattern bits.
- R5: A compared payload with anywhere from 1 to 24 wrong bits is one error event and raises `err_count_o` by exactly one.
- R6: During a run, `pass_o` is low only in the low half of the clock cycle that follows the edge capturing an erroneous payload. At all other times during a run it is high.
- R7: A cycle with `in_valid_i` low during a run is neither compared nor counted, and it does not advance the expected pattern.
- R8: After `bist_en_i` is sampled low, no payload is compared. `bist_active_o` falls and `pass_o` holds high if the run had no error event and low otherwise.
- R9: The held verdict and the count stay unchanged while idle. The edge that starts a new run clears both, so `pass_o` is high and `err_count_o` is zero from that edge.
- R10: `err_count_o` (CNT_W bits, 32 by default) saturates at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Payload clock |
| rst_i | input | 1 | Synchronous active-high reset |
| bist_en_i | input | 1 | Self-test enable; run length equals its high time |
| in_valid_i | input | 1 | Input payload valid |
| in_ready_o | output | 1 | Input ready |
| in_data_i | input | PAYLOAD_W (24) | Received payload |
| in_ctrl_i | input | CTRL_W (3) | Control bits travelling with the payload |
| out_valid_o | output | 1 | Output stream valid, zero during a run |
| out_ready_i | input | 1 | Output stream ready from the sink |
| out_data_o | output | PAYLOAD_W (24) | Output payload, zero during a run |
| out_ctrl_o | output | CTRL_W (3) | Output control bits, zero during a run |
| pass_o | output | 1 | Per-error strobe during a run, held verdict afterwards |
| bist_active_o | output | 1 | High while a run is in progress |
| err_count_o | output | CNT_W (32) | Saturating count of erroneous payloads |

## Verification
The stream outputs and `in_ready_o` are combinational, so the bench reads them 1 ns after driving each beat. `bist_active_o` and a cleared count appear one edge after the enable is sampled high. An erroneous payload driven before edge N shows as `pass_o` low in the low phase after edge N and as a higher count from edge N. The bench therefore drives every beat on a falling edge and judges the previous beat's outcome 1 ns after the next falling edge. It also reads `pass_o` 1 ns after the rising edge to confirm that the strobe is confined to the low half of the cycle.

// File: rtl/pb_bist_pkg.sv
package pb_bist_pkg;
  typedef enum logic [1:0] {
    RUN_IDLE  = 2'd0,
    RUN_SEED  = 2'd1,
    RUN_CHECK = 2'd2
  } run_state_e;
endpackage

// File: rtl/pb_pattern_gen.sv
module pb_pattern_gen #(
  parameter int ORDER = 7,
  parameter int TAP_A = 7,
  parameter int TAP_B = 6,
  parameter int WIDTH = 24
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_word_i,
  input  logic             step_i,
  output logic [WIDTH-1:0] expect_o
);
  logic [ORDER-1:0] state_q;
  logic [ORDER-1:0] chain [WIDTH+1];
  logic [WIDTH-1:0] bits;

  assign chain[0] = state_q;

  // unrolled LFSR: one stage per payload bit, oldest bit lands in the MSB
  for (genvar k = 0; k < WIDTH; k++) begin : g_stage
    logic fresh;
    assign fresh               = chain[k][TAP_A-1] ^ chain[k][TAP_B-1];
    assign chain[k+1]          = {chain[k][ORDER-2:0], fresh};
    assign bits[WIDTH-1-k]     = fresh;
  end

  assign expect_o = bits;

  always_ff @(posedge clk_i) begin
    if (rst_i)       state_q <= '0;
    else if (load_i) state_q <= load_word_i[ORDER-1:0];
    else if (step_i) state_q <= chain[WIDTH];
  end
endmodule

// File: rtl/pb_mismatch.sv
module pb_mismatch #(
  parameter int WIDTH = 24
) (
  input  logic [WIDTH-1:0] got_i,
  input  logic [WIDTH-1:0] exp_i,
  output logic             bad_o
);
  logic [WIDTH-1:0] diff;
  assign diff  = got_i ^ exp_i;
  assign bad_o = |diff;
endmodule

// File: rtl/pb_err_counter.sv
module pb_err_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             clear_i,
  input  logic             bump_i,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] CeilVal = {CNT_W{1'b1}};

  always_ff @(posedge clk_i) begin
    if (rst_i || clear_i)                 count_o <= '0;
    else if (bump_i && count_o != CeilVal) count_o <= count_o + 1'b1;
  end
endmodule

// File: rtl/pb_seq_ctrl.sv
module pb_seq_ctrl
  import pb_bist_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  input  logic valid_i,
  input  logic bad_i,
  output logic start_o,
  output logic load_o,
  output logic check_o,
  output logic strobe_o,
  output logic failed_o,
  output logic running_o
);
  run_state_e state_q;
  logic       hit;

  assign start_o   = (state_q == RUN_IDLE) && en_i;
  assign load_o    = (state_q == RUN_SEED) && en_i && valid_i;
  assign check_o   = (state_q == RUN_CHECK) && en_i && valid_i;
  assign hit       = check_o && bad_i;
  assign running_o = (state_q != RUN_IDLE);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q  <= RUN_IDLE;
      strobe_o <= 1'b0;
      failed_o <= 1'b0;
    end else begin
      strobe_o <= hit;
      if (start_o)  failed_o <= 1'b0;
      else if (hit) failed_o <= 1'b1;
      unique case (state_q)
        RUN_IDLE:  if (en_i) state_q <= RUN_SEED;
        RUN_SEED:  if (!en_i) state_q <= RUN_IDLE;
                   else if (valid_i) state_q <= RUN_CHECK;
        RUN_CHECK: if (!en_i) state_q <= RUN_IDLE;
        default:   state_q <= RUN_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/prbs_payload_bist.sv
module prbs_payload_bist #(
  parameter int PAYLOAD_W = 24,
  parameter int CTRL_W    = 3,
  parameter int CNT_W     = 32,
  parameter int ORDER     = 7,
  parameter int TAP_A     = 7,
  parameter int TAP_B     = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic                 bist_en_i,
  input  logic                 in_valid_i,
  output logic                 in_ready_o,
  input  logic [PAYLOAD_W-1:0] in_data_i,
  input  logic [CTRL_W-1:0]    in_ctrl_i,
  output logic                 out_valid_o,
  input  logic                 out_ready_i,
  output logic [PAYLOAD_W-1:0] out_data_o,
  output logic [CTRL_W-1:0]    out_ctrl_o,
  output logic                 pass_o,
  output logic                 bist_active_o,
  output logic [CNT_W-1:0]     err_count_o
);
  logic                 start, load, check, strobe, failed, running, bad;
  logic [PAYLOAD_W-1:0] expect_word;

  pb_seq_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .en_i     (bist_en_i),
    .valid_i  (in_valid_i),
    .bad_i    (bad),
    .start_o  (start),
    .load_o   (load),
    .check_o  (check),
    .strobe_o (strobe),
    .failed_o (failed),
    .running_o(running)
  );

  pb_pattern_gen #(
    .ORDER(ORDER), .TAP_A(TAP_A), .TAP_B(TAP_B), .WIDTH(PAYLOAD_W)
  ) u_gen (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .load_i     (load),
    .load_word_i(in_data_i),
    .step_i     (check),
    .expect_o   (expect_word)
  );

  pb_mismatch #(.WIDTH(PAYLOAD_W)) u_cmp (
    .got_i(in_data_i),
    .exp_i(expect_word),
    .bad_o(bad)
  );

  pb_err_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .clear_i(start),
    .bump_i (check && bad),
    .count_o(err_count_o)
  );

  // stream path: silenced and always accepting during a run
  assign out_valid_o   = running ? 1'b0 : in_valid_i;
  assign out_data_o    = running ? '0   : in_data_i;
  assign out_ctrl_o    = running ? '0   : in_ctrl_i;
  assign in_ready_o    = running ? 1'b1 : out_ready_i;
  assign bist_active_o = running;

  // strobe occupies the low phase of the cycle after the bad payload
  assign pass_o = running ? ~(strobe & ~clk_i) : ~failed;
endmodule

// File: rtl/prbs_payload_bist_sva.sv
module prbs_payload_bist_sva #(
  parameter int PAYLOAD_W = 24,
  parameter int CTRL_W    = 3,
  parameter int CNT_W     = 32
) (
  input logic                 clk_i,
  input logic                 rst_i,
  input logic                 in_ready_o,
  input logic                 out_valid_o,
  input logic [PAYLOAD_W-1:0] out_data_o,
  input logic [CTRL_W-1:0]    out_ctrl_o,
  input logic                 pass_o,
  input logic                 bist_active_o,
  input logic [CNT_W-1:0]     err_count_o
);
  // R3
  quiet_out_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    bist_active_o |-> (!out_valid_o && out_data_o == '0 && out_ctrl_o == '0));

  // R3
  ready_in_run_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    bist_active_o |-> in_ready_o);

  // R9
  fresh_count_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(bist_active_o) |-> err_count_o == '0);

  // R10
  count_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (err_count_o != $past(err_count_o)) |->
      (err_count_o == CNT_W'($past(err_count_o) + 1'b1) || err_count_o == '0));

  // R8
  held_verdict_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!bist_active_o && !$past(bist_active_o) && !$past(rst_i)) |-> $stable(pass_o));
endmodule

bind prbs_payload_bist prbs_payload_bist_sva #(
  .PAYLOAD_W(PAYLOAD_W), .CTRL_W(CTRL_W), .CNT_W(CNT_W)
) u_sva (
  .clk_i        (clk_i),
  .rst_i        (rst_i),
  .in_ready_o   (in_ready_o),
  .out_valid_o  (out_valid_o),
  .out_data_o   (out_data_o),
  .out_ctrl_o   (out_ctrl_o),
  .pass_o       (pass_o),
  .bist_active_o(bist_active_o),
  .err_count_o  (err_count_o)
);

// File: tb/prbs_payload_bist_bench.sv
module prbs_payload_bist_bench;
  localparam int ClkPeriod = 10;
  localparam int PW  = 24;
  localparam int CW  = 3;
  localparam int NW  = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bist_en = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [PW-1:0] in_data = '0;
  logic [CW-1:0] in_ctrl = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [PW-1:0] out_data;
  logic [CW-1:0] out_ctrl;
  logic          pass;
  logic          bist_active;
  logic [NW-1:0] err_count;

  int n_tests = 0;
  int n_fail  = 0;
  logic [6:0] hist;

  always #(ClkPeriod/2) clk = ~clk;

  prbs_payload_bist #(.PAYLOAD_W(PW), .CTRL_W(CW), .CNT_W(NW)) u_prbs_payload_bist (
    .clk_i(clk), .rst_i(rst), .bist_en_i(bist_en),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data), .in_ctrl_i(in_ctrl),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data), .out_ctrl_o(out_ctrl),
    .pass_o(pass), .bist_active_o(bist_active), .err_count_o(err_count)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // next 24 pattern bits, oldest in bit 23
  function automatic logic [PW-1:0] next_word();
    logic [PW-1:0] w;
    for (int j = PW-1; j >= 0; j--) begin
      logic nb;
      nb   = hist[6] ^ hist[5];
      hist = {hist[5:0], nb};
      w[j] = nb;
    end
    return w;
  endfunction

  task automatic cyc(input logic [PW-1:0] d, input logic v);
    @(negedge clk);
    in_data  = d;
    in_valid = v;
    #1;
  endtask

  task automatic start_run(input logic [6:0] seed);
    hist = seed;
    @(negedge clk);
    bist_en = 1'b1;
    cyc(24'h0, 1'b0);               // enable sampled at the preceding edge
    check("R3 active", 32'(bist_active), 32'd1);
    check("R9 cleared count", 32'(err_count), 32'd0);
    check("R9 pass restored", 32'(pass), 32'd1);
    cyc(next_word(), 1'b1);          // seed payload
  endtask

  task automatic stop_run();
    @(negedge clk);
    bist_en  = 1'b0;
    in_valid = 1'b0;
    cyc(24'h0, 1'b0);
    check("R8 inactive", 32'(bist_active), 32'd0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 pass", 32'(pass), 32'd1);
    check("R1 active", 32'(bist_active), 32'd0);
    check("R1 count", 32'(err_count), 32'd0);
  endtask

  task automatic t_passthrough();
    in_ctrl   = 3'b101;
    out_ready = 1'b0;
    cyc(24'hABCDEF, 1'b1);
    check("R2 data", 32'(out_data), 32'hABCDEF);
    check("R2 ctrl", 32'(out_ctrl), 32'h5);
    check("R2 valid", 32'(out_valid), 32'd1);
    check("R2 ready low", 32'(in_ready), 32'd0);
    out_ready = 1'b1;
    #1;
    check("R2 ready high", 32'(in_ready), 32'd1);
  endtask

  task automatic t_clean_run();
    start_run(7'h5A);
    check("R3 out valid", 32'(out_valid), 32'd0);
    check("R3 out data", 32'(out_data), 32'd0);
    check("R3 out ctrl", 32'(out_ctrl), 32'd0);
    check("R3 ready", 32'(in_ready), 32'd1);
    for (int i = 0; i < 12; i++) begin
      if (i % 4 == 3) cyc(24'hFFFFFF, 1'b0);   // R7 idle beat with junk
      else            cyc(next_word(), 1'b1);
      if (i > 0) check("R4 R7 no strobe", 32'(pass), 32'd1);
    end
    cyc(24'h0, 1'b0);
    check("R4 R7 clean count", 32'(err_count), 32'd0);
    stop_run();
    repeat (3) cyc(24'h123456, 1'b1);
    check("R8 clean verdict", 32'(pass), 32'd1);
    check("R8 no compare after stop", 32'(err_count), 32'd0);
  endtask

  task automatic t_error_run();
    start_run(7'h11);
    cyc(next_word(), 1'b1);
    cyc(next_word() ^ 24'h000001, 1'b1);     // one wrong bit
    cyc(next_word(), 1'b1);
    check("R6 strobe low phase", 32'(pass), 32'd0);
    check("R5 single bit", 32'(err_count), 32'd1);
    @(posedge clk); #1;
    check("R6 high phase", 32'(pass), 32'd1);
    cyc(next_word() ^ 24'hFFFFFF, 1'b1);     // all bits wrong
    cyc(next_word(), 1'b1);
    check("R6 second strobe", 32'(pass), 32'd0);
    check("R5 all bits one event", 32'(err_count), 32'd2);
    cyc(next_word(), 1'b1);
    check("R6 strobe ends", 32'(pass), 32'd1);
    stop_run();
    check("R8 fail verdict", 32'(pass), 32'd0);
    repeat (5) cyc(24'hDEAD00, 1'b1);
    check("R9 verdict held", 32'(pass), 32'd0);
    check("R9 count held", 32'(err_count), 32'd2);
    check("R2 after run", 32'(out_data), 32'hDEAD00);
  endtask

  task automatic t_saturate();
    start_run(7'h3C);
    for (int i = 0; i < 20; i++) cyc(~next_word(), 1'b1);
    cyc(24'h0, 1'b0);
    check("R10 saturated", 32'(err_count), 32'd15);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    bist_en = 1'b0;
    #1;
    check("R1 mid-run count", 32'(err_count), 32'd0);
    check("R1 mid-run pass", 32'(pass), 32'd1);
    check("R1 mid-run active", 32'(bist_active), 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_passthrough();
    t_clean_run();
    t_error_run();
    t_saturate();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule